// File: doc/BRIEF.md
# RC Pulse to Duty Mapper

This block turns one measured servo-style pulse width into a motor duty command. Each pulse width comes with a one-cycle valid strobe. The block first checks the pulse against a minimum width. It then tests for a low-end brake zone and measures the distance of the pulse from a learned neutral point. The duty is formed from that distance, minus a deadband, multiplied by a 16-bit fractional gain. Above neutral the forward gain is used; below neutral, in bidirectional mode, the reverse gain is used. The result is offset by a fixed duty floor and clamped to a power ceiling.

The calibration values come from the surrounding logic as plain inputs and are sampled together with the pulse. These values are the neutral point, the learned low pulse, the two gains, the minimum width, the deadband and the low-brake band. The outputs are the duty, a reverse flag, a brake request code and an error flag. All four outputs are registered and change together in the cycle after a valid strobe. Between strobes they hold their values.

Top module: `rc_duty_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared: `duty` = 0, `reverse` = 0, `brake_req` = 0, `pulse_err` = 0.
- R2: All outputs change only at the clock edge where `pulse_valid` is high, so they are visible one cycle after the strobe. In cycles without a strobe every output keeps its value.
- R3: A strobed pulse with `pulse_width` < `pulse_min` sets `pulse_err`, keeps `duty` unchanged, and clears `reverse` and `brake_req`. Any strobed pulse that is not short clears `pulse_err`.
- R4: The brake code encoding is: 0 = none, 1 = neutral brake, 2 = low brake. Code 3 never appears.
- R5: With `low_brake_en` set and `low_band` <= `low_cal`, a pulse below `low_cal` − `low_band` gives `duty` = 0, `brake_req` = 2 and `reverse` = 0.
- R6: With `low_band` > `low_cal`, the low-brake zone does not exist. No pulse then produces brake code 2.
- R7: For `pulse_width` >= `neutral_pos`, let net = `pulse_width` − `neutral_pos` − `dead_band`. When net > 0, `duty` = MIN_DUTY + floor(net × `fwd_gain` / 65536) and `reverse` = 0.
- R8: For `pulse_width` < `neutral_pos` with `bidir_en` set, let net = `neutral_pos` − `pulse_width` − `dead_band`. The duty uses `rev_gain` in place of `fwd_gain`, and `reverse` = 1.
- R9: For `pulse_width` < `neutral_pos` with `bidir_en` clear, `duty` = 0 and `reverse` = 0.
- R10: When net <= 0, `duty` is exactly 0 and `reverse` keeps the direction of the pulse.
- R11: Every zero-duty result other than low brake and error requests brake code 1 if `brake_en` is set, and code 0 otherwise. A driving result requests code 0.
- R12: `duty` never exceeds MAX_POWER. A computed value above it is replaced by MAX_POWER. Any nonzero duty is at least MIN_DUTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_valid | input | 1 | One-cycle strobe: `pulse_width` holds a new measurement |
| pulse_width | input | PW_W | Measured pulse width in timer ticks |
| pulse_min | input | PW_W | Shortest pulse accepted as valid |
| neutral_pos | input | PW_W | Learned neutral pulse width |
| low_cal | input | PW_W | Learned lowest pulse width |
| low_band | input | PW_W | Margin below `low_cal` where low brake starts |
| dead_band | input | PW_W | Deadband subtracted from the distance to neutral |
| fwd_gain | input | GAIN_W | Forward gain, value / 2^GAIN_W |
| rev_gain | input | GAIN_W | Reverse gain, value / 2^GAIN_W |
| bidir_en | input | 1 | Enables reverse drive below neutral |
| low_brake_en | input | 1 | Enables the low-brake zone |
| brake_en | input | 1 | Enables the neutral brake request |
| duty | output | DUTY_W | Duty command |
| reverse | output | 1 | Reverse direction flag |
| brake_req | output | 2 | Brake request code |
| pulse_err | output | 1 | Last strobed pulse was too short |

## Verification
The bench goes after the edges of the decision chain. It uses pulses exactly at the low-brake threshold and one tick below it. It uses a distance exactly equal to the deadband and one tick beyond it. A design that tested the deadband with >= would put out MIN_DUTY at neutral. A design that compared the low threshold inclusively would brake one tick early. A large reverse pulse must clamp to the ceiling. A design that widened the sum too little would wrap to a small duty instead. A short pulse must leave the old duty in place, and a design that zeroed it would be caught. The bench also sets a low band wider than the learned low value. Unguarded subtraction would wrap there and brake on almost every pulse.

// File: rtl/rc_duty_pkg.sv
// Package: shared types for the pulse-to-duty mapper.
// Assumes: the brake code is two bits wide and is decoded by the motor driver.
package rc_duty_pkg;

    // Brake request codes seen at the block's output.
    typedef enum logic [1:0] {
        BRK_NONE    = 2'd0,
        BRK_NEUTRAL = 2'd1,
        BRK_LOW     = 2'd2
    } brake_e;

    // Outcome of pulse classification.
    typedef enum logic [1:0] {
        CLS_ERROR = 2'd0,
        CLS_ZERO  = 2'd1,
        CLS_DRIVE = 2'd2
    } pulse_cls_e;

endpackage

// File: rtl/rc_pulse_classify.sv
// Module: rc_pulse_classify
// Purely combinational decision chain. It checks the pulse against the
// minimum width, then the low-brake zone, then the side of neutral and the
// deadband. It produces the class, brake code, direction, the net distance
// and the gain to apply.
// Assumes: all widths are unsigned tick counts of the same width.
module rc_pulse_classify
    import rc_duty_pkg::*;
#(
    parameter int PW_W   = 16,
    parameter int GAIN_W = 16
) (
    input  logic [PW_W-1:0]   pulse_width,
    input  logic [PW_W-1:0]   pulse_min,
    input  logic [PW_W-1:0]   neutral_pos,
    input  logic [PW_W-1:0]   low_cal,
    input  logic [PW_W-1:0]   low_band,
    input  logic [PW_W-1:0]   dead_band,
    input  logic [GAIN_W-1:0] fwd_gain,
    input  logic [GAIN_W-1:0] rev_gain,
    input  logic              bidir_en,
    input  logic              low_brake_en,
    input  logic              brake_en,
    output pulse_cls_e        cls,
    output brake_e            brake,
    output logic              rev_dir,
    output logic [PW_W-1:0]   net,
    output logic [GAIN_W-1:0] gain
);

    logic            too_short;
    logic            low_zone_ok;
    logic [PW_W-1:0] low_thresh;
    logic            in_low_zone;
    logic            below_neutral;
    logic [PW_W-1:0] distance;
    logic            beyond_band;
    brake_e          zero_brake;

    // Compute the low-brake threshold without wrapping below zero.
    always_comb begin
        low_zone_ok = (low_band <= low_cal);
        low_thresh  = low_cal - low_band;
        in_low_zone = low_brake_en && low_zone_ok && (pulse_width < low_thresh);
    end

    // Measure the distance from neutral and remove the deadband.
    always_comb begin
        too_short     = (pulse_width < pulse_min);
        below_neutral = (pulse_width < neutral_pos);
        distance      = below_neutral ? (neutral_pos - pulse_width)
                                      : (pulse_width - neutral_pos);
        beyond_band   = (distance > dead_band);
        net           = beyond_band ? (distance - dead_band) : '0;
        zero_brake    = brake_en ? BRK_NEUTRAL : BRK_NONE;
    end

    // Resolve the priority chain into one outcome.
    always_comb begin
        cls     = CLS_ZERO;
        brake   = BRK_NONE;
        rev_dir = 1'b0;
        gain    = fwd_gain;
        if (too_short) begin
            cls = CLS_ERROR;
        end else if (in_low_zone) begin
            cls   = CLS_ZERO;
            brake = BRK_LOW;
        end else if (below_neutral && !bidir_en) begin
            cls   = CLS_ZERO;
            brake = zero_brake;
        end else begin
            rev_dir = below_neutral;
            gain    = below_neutral ? rev_gain : fwd_gain;
            if (beyond_band) begin
                cls = CLS_DRIVE;
            end else begin
                cls   = CLS_ZERO;
                brake = zero_brake;
            end
        end
    end

endmodule

// File: rtl/rc_duty_scale.sv
// Module: rc_duty_scale
// Multiplies the net distance by a fractional gain and keeps the integer
// part. It then adds the duty floor and clamps the result to the ceiling.
// Combinational; the caller registers the result.
// Assumes: PW_W + 1 >= DUTY_W and MAX_POWER fits in DUTY_W bits.
module rc_duty_scale #(
    parameter int PW_W      = 16,
    parameter int GAIN_W    = 16,
    parameter int DUTY_W    = 11,
    parameter int MIN_DUTY  = 40,
    parameter int MAX_POWER = 1000
) (
    input  logic [PW_W-1:0]   net,
    input  logic [GAIN_W-1:0] gain,
    output logic [DUTY_W-1:0] duty_calc
);

    localparam int PROD_W = PW_W + GAIN_W;
    localparam int SUM_W  = PW_W + 1;

    localparam logic [SUM_W-1:0]  FLOOR_S = SUM_W'(MIN_DUTY);
    localparam logic [SUM_W-1:0]  CEIL_S  = SUM_W'(MAX_POWER);
    localparam logic [DUTY_W-1:0] CEIL_D  = DUTY_W'(MAX_POWER);

    logic [PROD_W-1:0] product;
    logic [PW_W-1:0]   whole;
    logic [SUM_W-1:0]  sum;

    // Fixed-point multiply, keep the integer bits only.
    always_comb begin
        product = PROD_W'(net) * PROD_W'(gain);
        whole   = product[PROD_W-1:GAIN_W];
    end

    // Offset by the floor and clamp to the power ceiling.
    always_comb begin
        sum       = FLOOR_S + SUM_W'(whole);
        duty_calc = (sum > CEIL_S) ? CEIL_D : sum[DUTY_W-1:0];
    end

endmodule

// File: rtl/rc_duty_outreg.sv
// Module: rc_duty_outreg
// Output register stage. It loads all four outputs together on a valid
// strobe and holds them otherwise. An error keeps the previous duty.
// Assumes: synchronous active-low reset.
module rc_duty_outreg
    import rc_duty_pkg::*;
#(
    parameter int DUTY_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  pulse_cls_e        cls,
    input  brake_e            brake,
    input  logic              rev_dir,
    input  logic [DUTY_W-1:0] duty_calc,
    output logic [DUTY_W-1:0] duty_q,
    output logic              rev_q,
    output logic [1:0]        brake_q,
    output logic              err_q
);

    // Capture the evaluated result on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q  <= '0;
            rev_q   <= 1'b0;
            brake_q <= BRK_NONE;
            err_q   <= 1'b0;
        end else if (load) begin
            unique case (cls)
                CLS_ERROR: begin
                    err_q   <= 1'b1;
                    rev_q   <= 1'b0;
                    brake_q <= BRK_NONE;
                end
                CLS_DRIVE: begin
                    err_q   <= 1'b0;
                    rev_q   <= rev_dir;
                    brake_q <= brake;
                    duty_q  <= duty_calc;
                end
                default: begin
                    err_q   <= 1'b0;
                    rev_q   <= rev_dir;
                    brake_q <= brake;
                    duty_q  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rc_duty_mapper.sv
// Module: rc_duty_mapper (top)
// Maps a strobed pulse width to duty, direction, brake request and error.
// The result appears one cycle after the strobe.
// Assumes: the calibration inputs are stable while the strobe is high.
module rc_duty_mapper
    import rc_duty_pkg::*;
#(
    parameter int PW_W      = 16,
    parameter int GAIN_W    = 16,
    parameter int DUTY_W    = 11,
    parameter int MIN_DUTY  = 40,
    parameter int MAX_POWER = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_valid,
    input  logic [PW_W-1:0]   pulse_width,
    input  logic [PW_W-1:0]   pulse_min,
    input  logic [PW_W-1:0]   neutral_pos,
    input  logic [PW_W-1:0]   low_cal,
    input  logic [PW_W-1:0]   low_band,
    input  logic [PW_W-1:0]   dead_band,
    input  logic [GAIN_W-1:0] fwd_gain,
    input  logic [GAIN_W-1:0] rev_gain,
    input  logic              bidir_en,
    input  logic              low_brake_en,
    input  logic              brake_en,
    output logic [DUTY_W-1:0] duty,
    output logic              reverse,
    output logic [1:0]        brake_req,
    output logic              pulse_err
);

    pulse_cls_e        cls;
    brake_e            brake;
    logic              rev_dir;
    logic [PW_W-1:0]   net;
    logic [GAIN_W-1:0] gain;
    logic [DUTY_W-1:0] duty_calc;

    rc_pulse_classify #(
        .PW_W   (PW_W),
        .GAIN_W (GAIN_W)
    ) u_classify (
        .pulse_width  (pulse_width),
        .pulse_min    (pulse_min),
        .neutral_pos  (neutral_pos),
        .low_cal      (low_cal),
        .low_band     (low_band),
        .dead_band    (dead_band),
        .fwd_gain     (fwd_gain),
        .rev_gain     (rev_gain),
        .bidir_en     (bidir_en),
        .low_brake_en (low_brake_en),
        .brake_en     (brake_en),
        .cls          (cls),
        .brake        (brake),
        .rev_dir      (rev_dir),
        .net          (net),
        .gain         (gain)
    );

    rc_duty_scale #(
        .PW_W      (PW_W),
        .GAIN_W    (GAIN_W),
        .DUTY_W    (DUTY_W),
        .MIN_DUTY  (MIN_DUTY),
        .MAX_POWER (MAX_POWER)
    ) u_scale (
        .net       (net),
        .gain      (gain),
        .duty_calc (duty_calc)
    );

    rc_duty_outreg #(
        .DUTY_W (DUTY_W)
    ) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pulse_valid),
        .cls       (cls),
        .brake     (brake),
        .rev_dir   (rev_dir),
        .duty_calc (duty_calc),
        .duty_q    (duty),
        .rev_q     (reverse),
        .brake_q   (brake_req),
        .err_q     (pulse_err)
    );

endmodule

// File: rtl/rc_duty_mapper_chk.sv
// Module: rc_duty_mapper_chk
// Port-level properties of the mapper, bound to every instance.
module rc_duty_mapper_chk #(
    parameter int PW_W      = 16,
    parameter int DUTY_W    = 11,
    parameter int MIN_DUTY  = 40,
    parameter int MAX_POWER = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pulse_valid,
    input logic [PW_W-1:0]   pulse_width,
    input logic [PW_W-1:0]   pulse_min,
    input logic              bidir_en,
    input logic [DUTY_W-1:0] duty,
    input logic              reverse,
    input logic [1:0]        brake_req,
    input logic              pulse_err
);

    localparam logic [DUTY_W-1:0] CEIL_D  = DUTY_W'(MAX_POWER);
    localparam logic [DUTY_W-1:0] FLOOR_D = DUTY_W'(MIN_DUTY);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_valid |=> $stable(duty) && $stable(reverse) && $stable(brake_req) && $stable(pulse_err));

    // R3
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid && (pulse_width < pulse_min) |=>
            pulse_err && (duty == $past(duty)) && !reverse && (brake_req == 2'd0));

    // R4
    brake_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brake_req != 2'd3);

    // R5
    low_brake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_req == 2'd2) |-> (duty == '0) && !reverse);

    // R9
    reverse_needs_bidir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid && !bidir_en |=> !reverse);

    // R12
    duty_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= CEIL_D);

    // R12
    duty_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty != '0) |-> (duty >= FLOOR_D));

endmodule

bind rc_duty_mapper rc_duty_mapper_chk #(
    .PW_W      (PW_W),
    .DUTY_W    (DUTY_W),
    .MIN_DUTY  (MIN_DUTY),
    .MAX_POWER (MAX_POWER)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_valid (pulse_valid),
    .pulse_width (pulse_width),
    .pulse_min   (pulse_min),
    .bidir_en    (bidir_en),
    .duty        (duty),
    .reverse     (reverse),
    .brake_req   (brake_req),
    .pulse_err   (pulse_err)
);

// File: tb/rc_duty_mapper_bench.sv
module rc_duty_mapper_bench;

    localparam int PW_W = 16;
    localparam int GAIN_W = 16;
    localparam int DUTY_W = 11;
    localparam int NVEC = 14;

    // Packing: {pulse[32:17], bidir[16], lowbrk[15], brk_en[14], duty[13:3], rev[2], brake[1:0]}
    localparam logic [32:0] VEC [NVEC] = '{
        {16'd32000, 1'b0, 1'b0, 1'b1, 11'd997,  1'b0, 2'd0}, // R7 forward
        {16'd33000, 1'b0, 1'b0, 1'b1, 11'd1000, 1'b0, 2'd0}, // R12 clamp
        {16'd28000, 1'b0, 1'b0, 1'b1, 11'd508,  1'b0, 2'd0}, // R7 mid
        {16'd24100, 1'b0, 1'b0, 1'b1, 11'd0,    1'b0, 2'd1}, // R10 inside deadband
        {16'd24160, 1'b0, 1'b0, 1'b1, 11'd0,    1'b0, 2'd1}, // R10 net exactly zero
        {16'd24161, 1'b0, 1'b0, 1'b1, 11'd40,   1'b0, 2'd0}, // R12 floor
        {16'd20000, 1'b1, 1'b0, 1'b1, 11'd450,  1'b1, 2'd0}, // R8 reverse
        {16'd20000, 1'b0, 1'b0, 1'b1, 11'd0,    1'b0, 2'd1}, // R9 no bidir, brake
        {16'd20000, 1'b0, 1'b0, 1'b0, 11'd0,    1'b0, 2'd0}, // R11 brake disabled
        {16'd23900, 1'b1, 1'b0, 1'b1, 11'd0,    1'b1, 2'd1}, // R10 reverse deadband
        {16'd15000, 1'b1, 1'b1, 1'b1, 11'd0,    1'b0, 2'd2}, // R5 low brake
        {16'd15680, 1'b1, 1'b1, 1'b1, 11'd911,  1'b1, 2'd0}, // R5 at threshold
        {16'd15000, 1'b1, 1'b0, 1'b1, 11'd984,  1'b1, 2'd0}, // R8 low brake off
        {16'd13000, 1'b1, 1'b0, 1'b1, 11'd1000, 1'b1, 2'd0}  // R12 reverse clamp
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_valid = 1'b0;
    logic [PW_W-1:0]   pulse_width = '0;
    logic [PW_W-1:0]   pulse_min = 16'd12800;
    logic [PW_W-1:0]   neutral_pos = 16'd24000;
    logic [PW_W-1:0]   low_cal = 16'd16000;
    logic [PW_W-1:0]   low_band = 16'd320;
    logic [PW_W-1:0]   dead_band = 16'd160;
    logic [GAIN_W-1:0] fwd_gain = 16'd8000;
    logic [GAIN_W-1:0] rev_gain = 16'd7000;
    logic              bidir_en = 1'b0;
    logic              low_brake_en = 1'b0;
    logic              brake_en = 1'b1;
    logic [DUTY_W-1:0] duty;
    logic              reverse;
    logic [1:0]        brake_req;
    logic              pulse_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rc_duty_mapper #(
        .PW_W (PW_W), .GAIN_W (GAIN_W), .DUTY_W (DUTY_W),
        .MIN_DUTY (40), .MAX_POWER (1000)
    ) u_rc_duty_mapper (
        .clk (clk), .rst_n (rst_n), .pulse_valid (pulse_valid),
        .pulse_width (pulse_width), .pulse_min (pulse_min),
        .neutral_pos (neutral_pos), .low_cal (low_cal), .low_band (low_band),
        .dead_band (dead_band), .fwd_gain (fwd_gain), .rev_gain (rev_gain),
        .bidir_en (bidir_en), .low_brake_en (low_brake_en), .brake_en (brake_en),
        .duty (duty), .reverse (reverse), .brake_req (brake_req), .pulse_err (pulse_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int d, input int r, input int b, input int e);
        check({req, " duty"}, int'(duty), d);
        check({req, " reverse"}, int'(reverse), r);
        check({req, " brake"}, int'(brake_req), b);
        check({req, " err"}, int'(pulse_err), e);
    endtask

    // Strobe one pulse; on return, outputs carry its result.
    task automatic strobe(input logic [15:0] pw, input logic bd, input logic lb, input logic be);
        @(negedge clk);
        pulse_width  = pw;
        bidir_en     = bd;
        low_brake_en = lb;
        brake_en     = be;
        pulse_valid  = 1'b1;
        @(negedge clk);
        pulse_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check_all("R1", 0, 0, 0, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][32:17], VEC[i][16], VEC[i][15], VEC[i][14]);
            check_all($sformatf("R7/R8 vec%0d", i), int'(VEC[i][13:3]), int'(VEC[i][2]),
                      int'(VEC[i][1:0]), 0);
        end

        // R2 latency and hold
        strobe(16'd28000, 1'b0, 1'b0, 1'b1);
        check("R2 load", int'(duty), 508);
        @(negedge clk);
        pulse_width = 16'd32000;
        pulse_valid = 1'b1;
        #1 check("R2 before edge", int'(duty), 508);
        @(negedge clk);
        pulse_valid = 1'b0;
        check("R2 after edge", int'(duty), 997);
        pulse_width = 16'd20000;
        bidir_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 idle hold", int'(duty), 997);
        check("R2 idle reverse", int'(reverse), 0);

        // R3 short pulse keeps duty, then clears
        strobe(16'd28000, 1'b0, 1'b0, 1'b1);
        strobe(16'd12799, 1'b1, 1'b0, 1'b1);
        check_all("R3 short", 508, 0, 0, 1);
        strobe(16'd12800, 1'b1, 1'b0, 1'b1);
        check_all("R3 recover", 1000, 1, 0, 0);

        // R6 band wider than learned low: no low brake
        low_cal = 16'd200;
        strobe(16'd13000, 1'b1, 1'b1, 1'b1);
        check_all("R6 guard", 1000, 1, 0, 0);
        low_cal = 16'd16000;

        // R5 one tick below threshold
        strobe(16'd15679, 1'b1, 1'b1, 1'b1);
        check_all("R5 below", 0, 0, 2, 0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 midrun", 0, 0, 0, 0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule